// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two 16-bit timer/counters. They share one byte of mode configuration and one byte of control, which carries a run bit and a sticky overflow flag for each timer. Each timer counts either a free-running internal tick or falling edges on its own external event pin. It can also be gated by an external enable pin. Four counting layouts are available: a 13-bit counter, a full 16-bit counter, an 8-bit counter with automatic reload, and a split layout. In the split layout timer 0 becomes two independent byte counters, and its upper byte borrows timer 1's run bit and overflow flag.

Software configures the block through a byte-wide register port. A write is a single-cycle strobe with an address and a data byte. A read is a combinational mux driven by a read address, so the counter bytes can be sampled live. The two overflow flags also appear as plain output pins, for use as interrupt requests. All pins are plain control and status signals. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads 0, both flags are 0 and both timers are stopped. Addresses: 0 mode, 1 control, 2 timer-0 low, 3 timer-0 high, 4 timer-1 low, 5 timer-1 high. Control bits: run0 at bit 0, run1 at bit 1, flag0 at bit 2, flag1 at bit 3. Mode byte: timer 0 in bits 3:0, timer 1 in bits 7:4. Within each nibble, bit 3 is gate, bit 2 is external select and bits 1:0 are the layout (0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split).
- R2: With external select at 0 and counting enabled, a timer advances by one on every internal tick. The tick fires on every TICK_DIV-th clock edge after reset release, the first being edge number TICK_DIV.
- R3: In layout 0 the counter is 13 bits wide: the high byte sits above low-byte bits 4:0, and low-byte bits 7:5 keep their value. Wrapping from all ones to zero sets the flag.
- R4: In layout 1 the two bytes form one 16-bit counter. The flag is set when it passes from FFFFh to 0000h.
- R5: In layout 2 only the low byte counts. When it advances from FFh it loads the high byte, the high byte keeps its value, and the flag is set.
- R6: In layout 3, timer 0's low byte counts under timer 0's own enable and sets flag0 when it wraps. Its high byte counts the internal tick whenever run1 is 1 and sets flag1 when it wraps.
- R7: Timer 1 in layout 3 holds both bytes. It resumes counting from the held value once it is switched to another layout.
- R8: While timer 0 is in layout 3, a wrap of timer 1 does not set flag1.
- R9: With gate at 1, a timer counts only while its run bit is 1 and its synchronized gate pin is high. With gate at 0, the run bit alone enables counting.
- R10: With external select at 1, the event pin passes through a two-flop synchronizer and is sampled on each tick. The count advances when one sample is high and the next is low, so at most one event is counted every two ticks.
- R11: An overflow flag stays set until a control write puts 0 in its bit. Writing 1 to a flag bit has no effect.
- R12: A write to a counter byte in the same cycle as an increment takes priority, and the byte holds the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev0_pin | input | 1 | Timer 0 external event pin |
| ev1_pin | input | 1 | Timer 1 external event pin |
| gate0_pin | input | 1 | Timer 0 external enable pin |
| gate1_pin | input | 1 | Timer 1 external enable pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| flag0 | output | 1 | Timer 0 overflow flag |
| flag1 | output | 1 | Timer 1 (or split high byte) overflow flag |

## Verification
The bench builds the block with TICK_DIV set to 4 and keeps the two-stage synchronizer. This makes every counting scenario last only tens of cycles, and it leaves a tick period long enough that a register write can be placed on the exact edge where an increment lands. Each counter is preloaded close to its wrap point, so the wraps of all four layouts and the split-mode flag routing can each be reached within a few ticks. Event pulses are held for three tick periods, so each falling edge survives both synchronizer stages and two tick samples.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmr_mode_e;

  // per-timer nibble of the mode byte
  typedef struct packed {
    logic      gate;
    logic      ext_sel;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_T0LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_T0HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_T1LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_T1HI = 3'd5;

  localparam int CTRL_RUN0  = 0;
  localparam int CTRL_RUN1  = 1;
  localparam int CTRL_FLAG0 = 2;
  localparam int CTRL_FLAG1 = 3;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int TICK_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign level = chain[STAGES-1];

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pair_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              inc_lo,
  input  logic              inc_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              ovf_lo,
  output logic              ovf_hi
);
  logic [BYTE_W-1:0] lo_n, hi_n;

  always_comb begin
    lo_n   = lo;
    hi_n   = hi;
    ovf_lo = 1'b0;
    ovf_hi = 1'b0;
    unique case (mode)
      MODE_13: if (inc_lo) begin
        {hi_n, lo_n[4:0]} = {hi, lo[4:0]} + 13'd1;
        ovf_lo            = &{hi, lo[4:0]};
      end
      MODE_16: if (inc_lo) begin
        {hi_n, lo_n} = {hi, lo} + 16'd1;
        ovf_lo       = &{hi, lo};
      end
      MODE_RELOAD: if (inc_lo) begin
        if (&lo) begin
          lo_n   = hi;
          ovf_lo = 1'b1;
        end else begin
          lo_n = lo + 1'b1;
        end
      end
      MODE_SPLIT: if (SPLIT_OK) begin
        if (inc_lo) begin
          lo_n   = lo + 1'b1;
          ovf_lo = &lo;
        end
        if (inc_hi) begin
          hi_n   = hi + 1'b1;
          ovf_hi = &hi;
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_n = wr_data;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RELOAD && inc_lo && lo == 8'hFF && !wr_lo && !wr_hi)
      |=> (lo == $past(hi)) && $stable(hi));

  // R4
  wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_16 && inc_lo && {hi, lo} == 16'hFFFF && !wr_lo && !wr_hi)
      |=> ({hi, lo} == 16'h0000));

  // R12
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo == $past(wr_data)));

  generate
    if (!SPLIT_OK) begin : g_hold
      // R7
      t1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SPLIT && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));
    end
  endgenerate

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pair_pkg::*;
#(
  parameter int TICK_DIV    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev0_pin,
  input  logic              ev1_pin,
  input  logic              gate0_pin,
  input  logic              gate1_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              flag0,
  output logic              flag1
);
  localparam int NPINS = 4;

  logic [BYTE_W-1:0] mode_r;
  logic              run0, run1;
  logic              tick;
  logic [NPINS-1:0]  pins, lvl;
  logic [1:0]        ev_samp, ev_fall;
  tmr_cfg_t          cfg0, cfg1;
  logic              ctrl_wr, split0;
  logic              inc0, inc1, inc0_hi;
  logic [BYTE_W-1:0] t0_lo, t0_hi, t1_lo, t1_hi;
  logic              ovf0_lo, ovf0_hi, ovf1_lo, ovf1_hi;
  logic              set0, set1;

  tmr_prescale #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  assign pins = {gate1_pin, gate0_pin, ev1_pin, ev0_pin};

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_sync
      tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pins[p]), .level(lvl[p])
      );
    end
    for (genvar e = 0; e < 2; e++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ev_samp[e] <= 1'b0;
        else if (tick) ev_samp[e] <= lvl[e];
      end
      assign ev_fall[e] = tick & ev_samp[e] & ~lvl[e];
      // R10
      ev_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fall[e] |=> !ev_fall[e]);
    end
  endgenerate

  assign cfg0    = tmr_cfg_t'(mode_r[3:0]);
  assign cfg1    = tmr_cfg_t'(mode_r[7:4]);
  assign split0  = (cfg0.mode == MODE_SPLIT);
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

  assign inc0    = run0 && (!cfg0.gate || lvl[2]) && (cfg0.ext_sel ? ev_fall[0] : tick);
  assign inc1    = run1 && (!cfg1.gate || lvl[3]) && (cfg1.ext_sel ? ev_fall[1] : tick);
  assign inc0_hi = split0 && run1 && tick;

  tmr_counter #(.SPLIT_OK(1'b1)) u_t0 (
    .clk(clk), .rst_n(rst_n), .mode(cfg0.mode),
    .inc_lo(inc0), .inc_hi(inc0_hi),
    .wr_lo(wr_en && wr_addr == ADDR_T0LO), .wr_hi(wr_en && wr_addr == ADDR_T0HI),
    .wr_data(wr_data), .lo(t0_lo), .hi(t0_hi),
    .ovf_lo(ovf0_lo), .ovf_hi(ovf0_hi)
  );

  tmr_counter #(.SPLIT_OK(1'b0)) u_t1 (
    .clk(clk), .rst_n(rst_n), .mode(cfg1.mode),
    .inc_lo(inc1), .inc_hi(1'b0),
    .wr_lo(wr_en && wr_addr == ADDR_T1LO), .wr_hi(wr_en && wr_addr == ADDR_T1HI),
    .wr_data(wr_data), .lo(t1_lo), .hi(t1_hi),
    .ovf_lo(ovf1_lo), .ovf_hi(ovf1_hi)
  );

  assign set0 = ovf0_lo;
  assign set1 = split0 ? ovf0_hi : (ovf1_lo | ovf1_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r <= '0;
      run0   <= 1'b0;
      run1   <= 1'b0;
      flag0  <= 1'b0;
      flag1  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_MODE) mode_r <= wr_data;
      if (ctrl_wr) begin
        run0 <= wr_data[CTRL_RUN0];
        run1 <= wr_data[CTRL_RUN1];
      end
      flag0 <= set0 | (flag0 & ~(ctrl_wr & ~wr_data[CTRL_FLAG0]));
      flag1 <= set1 | (flag1 & ~(ctrl_wr & ~wr_data[CTRL_FLAG1]));
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_MODE: rd_data = mode_r;
      ADDR_CTRL: rd_data = {4'b0000, flag1, flag0, run1, run0};
      ADDR_T0LO: rd_data = t0_lo;
      ADDR_T0HI: rd_data = t0_hi;
      ADDR_T1LO: rd_data = t1_lo;
      ADDR_T1HI: rd_data = t1_hi;
      default:   rd_data = '0;
    endcase
  end

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag0 && !ctrl_wr) |=> flag0);

  // R6
  flag0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf0_lo |=> flag0);

  // R8
  split_flag1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split0 && !ovf0_hi && !flag1) |=> !flag1);

endmodule

// File: tb/test_tmr_pair.sv
module test_tmr_pair;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev0_pin = 1'b0, ev1_pin = 1'b0, gate0_pin = 1'b0, gate1_pin = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       flag0, flag1;

  int checks = 0;
  int fails  = 0;
  int bcnt   = 0;

  always #4 clk = ~clk;

  tmr_pair #(.TICK_DIV(DIV), .SYNC_STAGES(2)) i_tmr_pair (
    .clk(clk), .rst_n(rst_n), .ev0_pin(ev0_pin), .ev1_pin(ev1_pin),
    .gate0_pin(gate0_pin), .gate1_pin(gate1_pin), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .flag0(flag0), .flag1(flag1)
  );

  // tick phase per R2: tick lands on edges where this count sits at DIV-1
  always @(posedge clk) begin
    if (!rst_n) bcnt <= 0;
    else        bcnt <= (bcnt == DIV - 1) ? 0 : bcnt + 1;
  end

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: got %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // run with the given run bits for exactly k ticks, flags kept
  task automatic run_ticks(input logic [1:0] runs, input int k);
    bus_write(3'd1, {6'b000011, runs});
    repeat (k * DIV - 2) @(negedge clk);
    bus_write(3'd1, 8'h0C);
  endtask

  task automatic clear_flags();
    bus_write(3'd1, 8'h00);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 6; a++) chk_reg("R1 reset", 3'(a), 8'h00);
    chk_bit("R1 flag0 reset", flag0, 1'b0);
    chk_bit("R1 flag1 reset", flag1, 1'b0);
  endtask

  task automatic t_mode16();
    bus_write(3'd0, 8'h01);
    run_ticks(2'b01, 7);
    chk_reg("R2 tick count", 3'd2, 8'h07);
    bus_write(3'd2, 8'hFE); bus_write(3'd3, 8'hFF);
    run_ticks(2'b01, 3);
    chk_reg("R4 lo after wrap", 3'd2, 8'h01);
    chk_reg("R4 hi after wrap", 3'd3, 8'h00);
    chk_bit("R4 flag0", flag0, 1'b1);
    chk_bit("R4 flag1 untouched", flag1, 1'b0);
  endtask

  task automatic t_flags();
    bus_write(3'd1, 8'h0C);
    chk_bit("R11 flag0 kept on write 1", flag0, 1'b1);
    run_ticks(2'b01, 2);
    chk_bit("R11 flag0 sticky", flag0, 1'b1);
    clear_flags();
    chk_bit("R11 flag0 cleared", flag0, 1'b0);
    bus_write(3'd1, 8'h04);
    chk_bit("R11 write 1 no set", flag0, 1'b0);
  endtask

  task automatic t_mode13();
    bus_write(3'd0, 8'h00);
    bus_write(3'd2, 8'hFE); bus_write(3'd3, 8'hFF);
    run_ticks(2'b01, 3);
    chk_reg("R3 hi", 3'd3, 8'h00);
    chk_reg("R3 lo keeps 7:5", 3'd2, 8'hE1);
    chk_bit("R3 flag0", flag0, 1'b1);
    clear_flags();
  endtask

  task automatic t_reload();
    bus_write(3'd0, 8'h02);
    bus_write(3'd3, 8'hF0); bus_write(3'd2, 8'hFE);
    run_ticks(2'b01, 5);
    chk_reg("R5 lo reloaded", 3'd2, 8'hF3);
    chk_reg("R5 hi held", 3'd3, 8'hF0);
    chk_bit("R5 flag0", flag0, 1'b1);
    clear_flags();
  endtask

  task automatic t_split();
    bus_write(3'd0, 8'h13);
    bus_write(3'd2, 8'hFE); bus_write(3'd3, 8'hFD);
    bus_write(3'd4, 8'h00); bus_write(3'd5, 8'h00);
    run_ticks(2'b11, 3);
    chk_reg("R6 split lo", 3'd2, 8'h01);
    chk_reg("R6 split hi", 3'd3, 8'h00);
    chk_bit("R6 flag0", flag0, 1'b1);
    chk_bit("R6 flag1 from high byte", flag1, 1'b1);
    clear_flags();
    bus_write(3'd2, 8'h00); bus_write(3'd3, 8'h00);
    run_ticks(2'b10, 3);
    chk_reg("R6 hi runs on run1 only", 3'd3, 8'h03);
    chk_reg("R6 lo stopped without run0", 3'd2, 8'h00);
    clear_flags();
  endtask

  task automatic t_split_t1();
    bus_write(3'd0, 8'h13);
    bus_write(3'd3, 8'h00);
    bus_write(3'd4, 8'hFE); bus_write(3'd5, 8'hFF);
    run_ticks(2'b10, 3);
    chk_reg("R8 t1 wrapped lo", 3'd4, 8'h01);
    chk_reg("R8 t1 wrapped hi", 3'd5, 8'h00);
    chk_bit("R8 flag1 not set by t1", flag1, 1'b0);
  endtask

  task automatic t_t1_hold();
    bus_write(3'd0, 8'h30);
    bus_write(3'd4, 8'h55); bus_write(3'd5, 8'h66);
    run_ticks(2'b10, 5);
    chk_reg("R7 t1 lo held", 3'd4, 8'h55);
    chk_reg("R7 t1 hi held", 3'd5, 8'h66);
    bus_write(3'd0, 8'h10);
    run_ticks(2'b10, 2);
    chk_reg("R7 t1 resumes", 3'd4, 8'h57);
  endtask

  task automatic t_gate();
    bus_write(3'd0, 8'h09);
    bus_write(3'd2, 8'h00); bus_write(3'd3, 8'h00);
    gate0_pin = 1'b0;
    run_ticks(2'b01, 4);
    chk_reg("R9 gated off", 3'd2, 8'h00);
    gate0_pin = 1'b1;
    repeat (4) @(negedge clk);
    run_ticks(2'b01, 3);
    chk_reg("R9 gated on", 3'd2, 8'h03);
    gate0_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_event();
    bus_write(3'd0, 8'h55);
    bus_write(3'd2, 8'h00); bus_write(3'd3, 8'h00);
    bus_write(3'd4, 8'h00); bus_write(3'd5, 8'h00);
    bus_write(3'd1, 8'h0F);
    for (int i = 0; i < 5; i++) begin
      ev0_pin = 1'b1;
      if (i < 3) ev1_pin = 1'b1;
      repeat (3 * DIV) @(negedge clk);
      ev0_pin = 1'b0; ev1_pin = 1'b0;
      repeat (3 * DIV) @(negedge clk);
    end
    bus_write(3'd1, 8'h0C);
    chk_reg("R10 t0 events", 3'd2, 8'h05);
    chk_reg("R10 t1 events", 3'd4, 8'h03);
    chk_reg("R10 t0 hi still", 3'd3, 8'h00);
  endtask

  task automatic t_prio();
    bus_write(3'd0, 8'h01);
    bus_write(3'd2, 8'h10);
    bus_write(3'd1, 8'h0D);
    do @(negedge clk); while (bcnt != DIV - 2);
    bus_write(3'd2, 8'h80);
    bus_write(3'd1, 8'h0C);
    chk_reg("R12 write beats increment", 3'd2, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode16();
    t_flags();
    t_mode13();
    t_reload();
    t_split();
    t_split_t1();
    t_t1_hold();
    t_gate();
    t_event();
    t_prio();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule